// File: doc/BRIEF.md
# Magnitude-Duty Gain Control Loop

This block closes a digital gain loop around a two-bit sign/magnitude sampler. Only the magnitude bit of each strobed sample is used. Over each fixed window of samples it counts how many had the magnitude bit high. At the end of the window it nudges an unsigned gain code by one step, so that the high fraction settles near one third. The sign bit carries no level information, so it is not an input. The gain code feeds an external variable-gain stage. Each code step stands for 0.25 dB, so the 8-bit default spans 63.75 dB.

A hold input freezes the loop. While hold is high, samples are discarded, the gain keeps the value it had when hold rose, and a load strobe may write an external gain value into the code. When hold falls, counting starts from an empty window. Any part of a window collected before the hold is thrown away.

Top module: `mag_duty_agc`

## Requirements
- R1: After reset the gain code equals GAIN_INIT (default 128) and the sample window is empty.
- R2: A window closes after exactly WIN_LEN samples with smp_vld high. Cycles with smp_vld low neither advance the window nor count a magnitude bit.
- R3: When a window closes with a high-magnitude count greater than TARGET+DEADBAND, the gain code decreases by one.
- R4: When a window closes with a count less than TARGET-DEADBAND, the gain code increases by one.
- R5: When a window closes with a count from TARGET-DEADBAND to TARGET+DEADBAND inclusive, the gain code is unchanged.
- R6: The gain code saturates: it stays at 0 when a decrease is called for at 0, and stays at all-ones when an increase is called for at all-ones. It never wraps.
- R7: While agc_hold is 1 and ext_load is 0, the gain code does not change, and samples presented during hold do not count.
- R8: With agc_hold at 1, ext_load at 1 writes ext_gain into the gain code at the next clock. With agc_hold at 0, ext_load has no effect.
- R9: Falling agc_hold starts a fresh, empty window. A partial window collected before the hold does not count.
- R10: Outside hold, the gain code changes only when a window closes, and by at most one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample strobe; one sample per high cycle |
| smp_mag | input | 1 | Magnitude bit of the strobed sample |
| agc_hold | input | 1 | 1 freezes the loop and allows an external load |
| ext_gain | input | GAIN_W | External gain value |
| ext_load | input | 1 | Load strobe for ext_gain; acts only while held |
| gain_code | output | GAIN_W | Gain code for the variable-gain stage |

## Verification
The bench runs with a 64-sample window, a target of 21 and a deadband of 2. From a fixed starting gain it sweeps every possible high-magnitude count from 0 to 64, which exercises every decision boundary, including 18, 19, 23 and 24. Odd counts are sent with idle cycles between strobes, which shows that gaps do not shift the window.

Further sequences cover the following cases:
- loading near each end of the code range, then repeating windows, to separate saturation from wrap-around;
- interrupting a window with a hold while samples continue to arrive, to expose any leftover count;
- sampling the gain one sample before a window closes, to catch early updates;
- pulsing the load strobe outside hold, to confirm it is ignored.

// File: rtl/agc_pkg.sv
package agc_pkg;
    typedef enum logic [1:0] {
        STEP_KEEP = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_LOAD = 2'd3
    } step_e;
endpackage

// File: rtl/duty_window.sv
module duty_window #(
    parameter int WIN_LEN = 1024,
    localparam int IDX_W  = $clog2(WIN_LEN),
    localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             vld_i,
    input  logic             mag_i,
    output logic             done_o,
    output logic [CNT_W-1:0] total_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] acc;
        logic             done;
        logic [CNT_W-1:0] total;
    } win_t;

    win_t win_d, win_q;
    logic [CNT_W-1:0] mag_ext;

    always_comb begin
        mag_ext    = {{(CNT_W-1){1'b0}}, mag_i};
        win_d      = win_q;
        win_d.done = 1'b0;
        if (clear_i) begin
            win_d.idx = '0;
            win_d.acc = '0;
        end else if (vld_i) begin
            if (win_q.idx == LAST_IDX) begin
                win_d.done  = 1'b1;
                win_d.total = win_q.acc + mag_ext;
                win_d.idx   = '0;
                win_d.acc   = '0;
            end else begin
                win_d.idx = win_q.idx + 1'b1;
                win_d.acc = win_q.acc + mag_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign done_o  = win_q.done;
    assign total_o = win_q.total;

    // R2
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.acc <= CNT_W'(win_q.idx));

    // R2
    total_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.done |-> (win_q.total <= CNT_W'(WIN_LEN)));

    // R9
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (win_q.idx == '0 && win_q.acc == '0 && !win_q.done));
endmodule

// File: rtl/gain_stepper.sv
module gain_stepper
    import agc_pkg::*;
#(
    parameter int GAIN_W    = 8,
    parameter int CNT_W     = 11,
    parameter int TARGET    = 341,
    parameter int DEADBAND  = 8,
    parameter int GAIN_INIT = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              load_i,
    input  logic [GAIN_W-1:0] ext_i,
    input  logic              done_i,
    input  logic [CNT_W-1:0]  total_i,
    output logic [GAIN_W-1:0] gain_o
);
    localparam int HI_LIM = TARGET + DEADBAND;
    localparam int LO_LIM = TARGET - DEADBAND;
    localparam logic [GAIN_W-1:0] GAIN_MAX = '1;
    localparam logic [GAIN_W-1:0] GAIN_RST = GAIN_W'(GAIN_INIT);

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
    } gst_t;

    gst_t  g_d, g_q;
    step_e step;
    int    cnt_i;

    always_comb begin
        cnt_i = int'({1'b0, total_i});
        step  = STEP_KEEP;
        if (hold_i) begin
            if (load_i) step = STEP_LOAD;
        end else if (done_i) begin
            if (cnt_i > HI_LIM && g_q.gain != '0)           step = STEP_DOWN;
            else if (cnt_i < LO_LIM && g_q.gain != GAIN_MAX) step = STEP_UP;
        end
    end

    always_comb begin
        g_d = g_q;
        unique case (step)
            STEP_UP:   g_d.gain = g_q.gain + 1'b1;
            STEP_DOWN: g_d.gain = g_q.gain - 1'b1;
            STEP_LOAD: g_d.gain = ext_i;
            default:   g_d.gain = g_q.gain;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.gain <= GAIN_RST;
        end else begin
            g_q <= g_d;
        end
    end

    assign gain_o = g_q.gain;

    // R10
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> (({1'b0, g_q.gain} <= {1'b0, $past(g_q.gain)} + 1'b1) &&
                     ({1'b0, g_q.gain} + 1'b1 >= {1'b0, $past(g_q.gain)})));

    // R10
    quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !done_i) |=> $stable(g_q.gain));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !load_i) |=> $stable(g_q.gain));

    // R8
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && load_i) |=> (g_q.gain == $past(ext_i)));

    // R6
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && g_q.gain == GAIN_MAX) |=> (g_q.gain != '0));

    // R6
    no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && g_q.gain == '0) |=> (g_q.gain != GAIN_MAX));
endmodule

// File: rtl/mag_duty_agc.sv
module mag_duty_agc #(
    parameter int WIN_LEN   = 1024,
    parameter int TARGET    = 341,
    parameter int DEADBAND  = 8,
    parameter int GAIN_W    = 8,
    parameter int GAIN_INIT = 128,
    localparam int CNT_W    = $clog2(WIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic              smp_mag,
    input  logic              agc_hold,
    input  logic [GAIN_W-1:0] ext_gain,
    input  logic              ext_load,
    output logic [GAIN_W-1:0] gain_code
);
    logic             win_done;
    logic [CNT_W-1:0] win_total;

    duty_window #(.WIN_LEN(WIN_LEN)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (agc_hold),
        .vld_i   (smp_vld),
        .mag_i   (smp_mag),
        .done_o  (win_done),
        .total_o (win_total)
    );

    gain_stepper #(
        .GAIN_W    (GAIN_W),
        .CNT_W     (CNT_W),
        .TARGET    (TARGET),
        .DEADBAND  (DEADBAND),
        .GAIN_INIT (GAIN_INIT)
    ) u_stepper (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (agc_hold),
        .load_i  (ext_load),
        .ext_i   (ext_gain),
        .done_i  (win_done),
        .total_i (win_total),
        .gain_o  (gain_code)
    );
endmodule

// File: tb/mag_duty_agc_test.sv
module mag_duty_agc_test;
    localparam int CLK_PER = 10;
    localparam int WIN     = 64;
    localparam int TGT     = 21;
    localparam int DB      = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic       smp_mag = 1'b0;
    logic       agc_hold = 1'b0;
    logic [7:0] ext_gain = 8'd0;
    logic       ext_load = 1'b0;
    logic [7:0] gain_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    mag_duty_agc #(.WIN_LEN(WIN), .TARGET(TGT), .DEADBAND(DB),
                   .GAIN_W(8), .GAIN_INIT(128)) uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_mag(smp_mag),
        .agc_hold(agc_hold), .ext_gain(ext_gain), .ext_load(ext_load),
        .gain_code(gain_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_gain(input logic [7:0] v);
        @(negedge clk);
        agc_hold = 1'b1; ext_gain = v; ext_load = 1'b1;
        @(negedge clk);
        ext_load = 1'b0; agc_hold = 1'b0;
    endtask

    task automatic feed(input int n, input int highs, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_vld = 1'b1; smp_mag = (i < highs);
            if (gaps) begin
                @(negedge clk);
                smp_vld = 1'b0; smp_mag = 1'b1;
            end
        end
        @(negedge clk);
        smp_vld = 1'b0; smp_mag = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic int expect_step(input int g, input int k);
        int r;
        r = g;
        if (k > TGT + DB && g > 0) r = g - 1;
        else if (k < TGT - DB && g < 255) r = g + 1;
        return r;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset gain", gain_code, 128);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 gain after reset release", gain_code, 128);

        // R3 R4 R5 R2: exhaustive density sweep, gaps on odd counts
        for (int k = 0; k <= WIN; k++) begin
            load_gain(8'd100);
            feed(WIN, k, (k % 2) == 1);
            settle();
            check($sformatf("R3/R4/R5 window count %0d", k), gain_code,
                  expect_step(100, k));
        end

        // R10: no change one sample before window end
        load_gain(8'd50);
        feed(WIN - 1, WIN - 1, 1'b0);
        settle();
        check("R10 gain before window closes", gain_code, 50);
        feed(1, 1, 1'b0);
        settle();
        check("R10 gain after last sample", gain_code, 49);

        // R6: saturation at top and bottom
        load_gain(8'd254);
        feed(WIN, 0, 1'b0); settle();
        check("R6 rise to max", gain_code, 255);
        feed(WIN, 0, 1'b0); settle();
        check("R6 hold at max", gain_code, 255);
        load_gain(8'd1);
        feed(WIN, WIN, 1'b0); settle();
        check("R6 fall to zero", gain_code, 0);
        feed(WIN, WIN, 1'b0); settle();
        check("R6 hold at zero", gain_code, 0);

        // R8: load ignored outside hold
        load_gain(8'd90);
        @(negedge clk);
        ext_gain = 8'd7; ext_load = 1'b1;
        @(negedge clk);
        ext_load = 1'b0;
        settle();
        check("R8 load without hold ignored", gain_code, 90);

        // R7: held over more than a window of all-low samples
        @(negedge clk);
        agc_hold = 1'b1;
        feed(2 * WIN, 0, 1'b0);
        settle();
        check("R7 gain frozen while held", gain_code, 90);
        @(negedge clk);
        agc_hold = 1'b0;
        feed(WIN, TGT, 1'b0); settle();
        check("R7 held samples not counted", gain_code, 90);

        // R9: partial window discarded on hold
        feed(40, 40, 1'b0);
        @(negedge clk);
        agc_hold = 1'b1;
        feed(5, 5, 1'b0);
        @(negedge clk);
        agc_hold = 1'b0;
        settle();
        check("R9 gain across hold", gain_code, 90);
        feed(WIN, TGT, 1'b0); settle();
        check("R9 fresh window after hold", gain_code, 90);
        feed(WIN, 0, 1'b0); settle();
        check("R4 after hold release", gain_code, 91);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule